// File: doc/BRIEF.md
# Flash SPI Master Word FIFO and Status Registers

This block sits on the register side of a flash-oriented SPI master. Software writes 32-bit words to one of four transmit data addresses. The address it uses records how many bytes of that word are valid: one, two, three or all four. Each word and its byte count go into a transmit FIFO. A serial shifter, which is outside this block, drains that FIFO through a valid/pop handshake. Words that the shifter receives are pushed into a receive FIFO, and software reads them back from a single data address.

The block also computes the status flags from the FIFO fill levels and two programmable watermarks. Beside them sits a sticky overflow flag. An enable mask is kept in separate set and clear registers, and the interrupt line is the OR of all enabled status flags. A global enable bit gates the shifter handshake. Clearing that bit also empties the receive FIFO.

Top module: `spiw_regs_top`

## Requirements
- R1: After reset the status register (0x04) reads 0x04, the interrupt mask (0x10) reads 0, the enable register (0x14) reads 0, both watermark registers (0x28 TX, 0x2C RX) read 1, and `irq` and `ctrl_on` are low.
- R2: A write to 0x1C queues a word with byte count 4, and writes to 0x80, 0x84 and 0x88 queue words with byte counts 1, 2 and 3. While enabled, `tx_valid`, `tx_word` and `tx_nbytes` present the oldest queued word, and `tx_pop` removes it.
- R3: The transmit FIFO holds DEPTH (63) words. Status bit 3 is set while it is full. A write to a full FIFO is dropped and sets the sticky overflow status bit 0.
- R4: Status bit 2 is set while the transmit FIFO level is below the TX watermark at 0x28.
- R5: Status bit 4 is set while the receive FIFO level is at or above the RX watermark at 0x2C.
- R6: While enabled, words on `rx_word` with `rx_push` fill the receive FIFO. A read of 0x20 returns them in order on `rd_data` in the cycle after the read strobe. A read of 0x20 while the receive FIFO is empty returns 0 and changes nothing.
- R7: Writing ones to 0x04 clears the sticky bit 0. Status bits 2, 3 and 4 follow the FIFO levels and are not cleared by such writes. Status bits 1, 5 and 6 read 0.
- R8: Writing ones to 0x08 sets bits of the 7-bit interrupt mask, and writing ones to 0x0C clears them. The mask reads back at 0x10.
- R9: `irq` is high whenever a status bit and its mask bit are both set. It is registered and follows the status register by one cycle.
- R10: Bit 0 of 0x14 enables the block and is mirrored on `ctrl_on`. While it is clear, `tx_valid` is low, `rx_push` is ignored and the receive FIFO is emptied. Transmit writes are still queued while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| tx_valid | output | 1 | Transmit word available to the shifter |
| tx_word | output | 32 | Oldest transmit word |
| tx_nbytes | output | 3 | Valid bytes in `tx_word` (1 to 4) |
| tx_pop | input | 1 | Shifter consumes the presented word |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_word | input | 32 | Received word |
| ctrl_on | output | 1 | Controller enable bit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the shifter only asserts `tx_pop` while `tx_valid` is high. They also assume that a write and a read never target the same FIFO in a way that needs both in one cycle on one port. The stimulus keeps within this because the bench pops only after it has observed `tx_valid`, and it drives one strobe per cycle. The bench changes inputs on falling edges. It samples status only after the two register stages between a FIFO level and `irq` have settled.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  localparam int WORD_W = 32;
  localparam int ST_W   = 7;

  localparam logic [7:0] A_STATUS = 8'h04;
  localparam logic [7:0] A_IEN    = 8'h08;
  localparam logic [7:0] A_IDIS   = 8'h0C;
  localparam logic [7:0] A_IMASK  = 8'h10;
  localparam logic [7:0] A_ENABLE = 8'h14;
  localparam logic [7:0] A_TX4    = 8'h1C;
  localparam logic [7:0] A_RXD    = 8'h20;
  localparam logic [7:0] A_TXWM   = 8'h28;
  localparam logic [7:0] A_RXWM   = 8'h2C;
  localparam logic [7:0] A_TX1    = 8'h80;
  localparam logic [7:0] A_TX2    = 8'h84;
  localparam logic [7:0] A_TX3    = 8'h88;

  localparam int SB_OVF    = 0;
  localparam int SB_TXLOW  = 2;
  localparam int SB_TXFULL = 3;
  localparam int SB_RXHIT  = 4;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [1:0]        nb_m1;
  } tx_entry_t;

  // Valid-byte count minus one for a transmit address; bit 2 flags a hit.
  function automatic logic [2:0] tx_addr_decode(input logic [7:0] a);
    case (a)
      A_TX4:   return 3'b111;
      A_TX1:   return 3'b100;
      A_TX2:   return 3'b101;
      A_TX3:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/spiw_fifo.sv
module spiw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 63,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp_q];
  assign level   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= bump(wp_q);
      if (pop_ok)  rp_q <= bump(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (level == $past(level))); // R3

  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> (level == $past(level))); // R6

endmodule

// File: rtl/spiw_irq.sv
module spiw_irq
  import spiw_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   tx_level,
  input  logic [LW-1:0]   rx_level,
  input  logic            tx_full,
  input  logic [LW-1:0]   tx_wm,
  input  logic [LW-1:0]   rx_wm,
  input  logic            ovf_set,
  input  logic            w1c_we,
  input  logic            ien_we,
  input  logic            idis_we,
  input  logic [ST_W-1:0] wdata,
  output logic [ST_W-1:0] status_q,
  output logic [ST_W-1:0] mask_q,
  output logic            irq
);

  logic [ST_W-1:0] status_d;

  always_comb begin
    status_d            = '0;
    status_d[SB_OVF]    = (status_q[SB_OVF] && !(w1c_we && wdata[SB_OVF])) || ovf_set;
    status_d[SB_TXLOW]  = (tx_level < tx_wm);
    status_d[SB_TXFULL] = tx_full;
    status_d[SB_RXHIT]  = (rx_level >= rx_wm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_d;
      if (ien_we)       mask_q <= mask_q | wdata;
      else if (idis_we) mask_q <= mask_q & ~wdata;
      irq <= |(status_q & mask_q);
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status_q[SB_OVF] && !w1c_we) |=> status_q[SB_OVF]); // R3

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq); // R9

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    ien_we |=> ((mask_q & $past(wdata)) == $past(wdata))); // R8

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    idis_we |=> ((mask_q & $past(wdata)) == '0)); // R8

endmodule

// File: rtl/spiw_regs_top.sv
module spiw_regs_top
  import spiw_pkg::*;
#(
  parameter int DEPTH    = 63,
  parameter int TXWM_RST = 1,
  parameter int RXWM_RST = 1,
  localparam int LW      = $clog2(DEPTH + 1),
  localparam int TXE_W   = $bits(tx_entry_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [7:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_word,
  output logic [2:0]        tx_nbytes,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [WORD_W-1:0] rx_word,
  output logic              ctrl_on,
  output logic              irq
);

  logic            en_q;
  logic [LW-1:0]   txwm_q, rxwm_q;
  logic [2:0]      tx_dec;
  logic            tx_wr;
  tx_entry_t       tx_in, tx_head;
  logic [TXE_W-1:0] tx_head_raw;
  logic [LW-1:0]   tx_level, rx_level;
  logic            tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] rx_head;
  logic            rx_rd, rx_wr;
  logic [ST_W-1:0] status_q, mask_q;
  logic            w1c_we, ien_we, idis_we;

  // ---------------- write decode ----------------
  assign tx_dec  = tx_addr_decode(wr_addr);
  assign tx_wr   = wr_en && tx_dec[2];
  assign tx_in   = '{word: wr_data, nb_m1: tx_dec[1:0]};
  assign w1c_we  = wr_en && (wr_addr == A_STATUS);
  assign ien_we  = wr_en && (wr_addr == A_IEN);
  assign idis_we = wr_en && (wr_addr == A_IDIS);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      txwm_q <= LW'(TXWM_RST);
      rxwm_q <= LW'(RXWM_RST);
    end else if (wr_en) begin
      case (wr_addr)
        A_ENABLE: en_q   <= wr_data[0];
        A_TXWM:   txwm_q <= wr_data[LW-1:0];
        A_RXWM:   rxwm_q <= wr_data[LW-1:0];
        default:  ;
      endcase
    end
  end

  assign ctrl_on = en_q;

  // ---------------- transmit path ----------------
  spiw_fifo #(.W(TXE_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .flush     (1'b0),
    .push      (tx_wr),
    .push_data (tx_in),
    .pop       (tx_pop && tx_valid),
    .head      (tx_head_raw),
    .level     (tx_level),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  assign tx_head   = tx_entry_t'(tx_head_raw);
  assign tx_valid  = en_q && !tx_empty;
  assign tx_word   = tx_head.word;
  assign tx_nbytes = {1'b0, tx_head.nb_m1} + 3'd1;

  // ---------------- receive path ----------------
  assign rx_wr = rx_push && en_q;
  assign rx_rd = rd_en && (rd_addr == A_RXD) && !rx_empty;

  spiw_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .flush     (!en_q),
    .push      (rx_wr),
    .push_data (rx_word),
    .pop       (rx_rd),
    .head      (rx_head),
    .level     (rx_level),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  // ---------------- status and interrupt ----------------
  spiw_irq #(.LW(LW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_full  (tx_full),
    .tx_wm    (txwm_q),
    .rx_wm    (rxwm_q),
    .ovf_set  (tx_wr && tx_full),
    .w1c_we   (w1c_we),
    .ien_we   (ien_we),
    .idis_we  (idis_we),
    .wdata    (wr_data[ST_W-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  // ---------------- read mux ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_STATUS: rd_data <= WORD_W'(status_q);
        A_IMASK:  rd_data <= WORD_W'(mask_q);
        A_ENABLE: rd_data <= WORD_W'(en_q);
        A_TXWM:   rd_data <= WORD_W'(txwm_q);
        A_RXWM:   rd_data <= WORD_W'(rxwm_q);
        A_RXD:    rd_data <= rx_empty ? '0 : rx_head;
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_RX_FLUSHED_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (rx_level == '0)); // R10

  AST_RXD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == A_RXD) && rx_empty) |=> (rd_data == '0)); // R6

  AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !tx_valid) |=> (tx_level == $past(tx_level) + LW'($past(tx_wr && !tx_full)))); // R2

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    tx_full |=> status_q[SB_TXFULL]); // R3

endmodule

// File: tb/spiw_regs_top_test.sv
`timescale 1ns/1ps
module spiw_regs_top_test;

  localparam int DEPTH = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_valid;
  logic [31:0] tx_word;
  logic [2:0]  tx_nbytes;
  logic        tx_pop = 1'b0;
  logic        rx_push = 1'b0;
  logic [31:0] rx_word = '0;
  logic        ctrl_on;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spiw_regs_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_nbytes(tx_nbytes), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word),
    .ctrl_on(ctrl_on), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rxp(input logic [31:0] w);
    rx_push = 1'b1; rx_word = w;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [31:0] w, input logic [2:0] nb);
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, tx_word, w);
    chk(req, {29'd0, tx_nbytes}, {29'd0, nb});
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle();
    rd(8'h04, d); chk("R1 status", d, 32'h04);
    rd(8'h10, d); chk("R1 mask", d, 0);
    rd(8'h14, d); chk("R1 enable", d, 0);
    rd(8'h28, d); chk("R1 txwm", d, 1);
    rd(8'h2C, d); chk("R1 rxwm", d, 1);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 ctrl_on", {31'd0, ctrl_on}, 0);
  endtask

  task automatic t_tx_sizes();
    logic [31:0] d;
    wr(8'h14, 1);
    chk("R10 ctrl_on", {31'd0, ctrl_on}, 1);
    wr(8'h1C, 32'hA0A0_0004);
    wr(8'h80, 32'hB0B0_0001);
    wr(8'h84, 32'hC0C0_0002);
    wr(8'h88, 32'hD0D0_0003);
    settle();
    rd(8'h04, d); chk("R4 tx level above wm", d & 32'h04, 0);
    pop_expect("R2 word4", 32'hA0A0_0004, 3'd4);
    pop_expect("R2 word1", 32'hB0B0_0001, 3'd1);
    pop_expect("R2 word2", 32'hC0C0_0002, 3'd2);
    pop_expect("R2 word3", 32'hD0D0_0003, 3'd3);
    chk("R2 drained", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) wr(8'h1C, 32'h100 + i);
    settle();
    rd(8'h04, d); chk("R3 full flag", d, 32'h08);
    wr(8'h80, 32'hDEAD_BEEF);
    settle();
    rd(8'h04, d); chk("R3 overflow sticky", d, 32'h09);
    for (int i = 0; i < DEPTH; i++) begin
      if (tx_word !== 32'h100 + i) begin
        chk("R3 fifo order", tx_word, 32'h100 + i);
      end
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    end
    chk("R3 extra write dropped", {31'd0, tx_valid}, 0);
    settle();
    rd(8'h04, d); chk("R3 overflow kept after drain", d, 32'h05);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h04, 32'h7F);
    settle();
    rd(8'h04, d); chk("R7 w1c clears sticky, keeps level bit", d, 32'h04);
    wr(8'h04, 32'h04);
    settle();
    rd(8'h04, d); chk("R7 level bit not cleared", d, 32'h04);
  endtask

  task automatic t_txwm();
    logic [31:0] d;
    wr(8'h28, 4);
    for (int i = 0; i < 3; i++) wr(8'h1C, i);
    settle();
    rd(8'h04, d); chk("R4 3 below wm 4", d & 32'h04, 32'h04);
    wr(8'h1C, 3);
    settle();
    rd(8'h04, d); chk("R4 4 not below wm 4", d & 32'h04, 0);
    for (int i = 0; i < 4; i++) pop_expect("R4 drain", i, 3'd4);
    wr(8'h28, 1);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    rxp(32'h1111_1111); rxp(32'h2222_2222); rxp(32'h3300_0000);
    settle();
    rd(8'h04, d); chk("R5 rx at wm 1", d & 32'h10, 32'h10);
    rd(8'h20, d); chk("R6 rx first", d, 32'h1111_1111);
    rd(8'h20, d); chk("R6 rx second", d, 32'h2222_2222);
    rd(8'h20, d); chk("R6 rx third", d, 32'h3300_0000);
    rd(8'h20, d); chk("R6 empty read zero", d, 0);
    settle();
    rd(8'h04, d); chk("R5 rx empty below wm", d & 32'h10, 0);
    wr(8'h2C, 3);
    rxp(32'hA); rxp(32'hB);
    settle();
    rd(8'h04, d); chk("R5 2 below wm 3", d & 32'h10, 0);
    rxp(32'hC);
    settle();
    rd(8'h04, d); chk("R5 3 reaches wm 3", d & 32'h10, 32'h10);
    rd(8'h20, d); chk("R6 drain a", d, 32'hA);
    rd(8'h20, d); chk("R6 drain b", d, 32'hB);
    rd(8'h20, d); chk("R6 drain c", d, 32'hC);
    wr(8'h2C, 1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FF04);
    rd(8'h10, d); chk("R8 mask set", d, 32'h04);
    settle();
    chk("R9 irq on tx low", {31'd0, irq}, 1);
    wr(8'h0C, 32'h04);
    rd(8'h10, d); chk("R8 mask clear", d, 0);
    settle();
    chk("R9 irq masked", {31'd0, irq}, 0);
    wr(8'h08, 32'h10);
    settle();
    chk("R9 irq rx empty", {31'd0, irq}, 0);
    rxp(32'h55);
    settle();
    chk("R9 irq on rx", {31'd0, irq}, 1);
    rd(8'h20, d); chk("R6 irq word", d, 32'h55);
    settle();
    chk("R9 irq drops", {31'd0, irq}, 0);
    wr(8'h0C, 32'h7F);
    rd(8'h10, d); chk("R8 mask all clear", d, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    rxp(32'h77); rxp(32'h88);
    wr(8'h14, 0);
    chk("R10 ctrl_on off", {31'd0, ctrl_on}, 0);
    settle();
    rd(8'h04, d); chk("R10 rx flushed status", d & 32'h10, 0);
    rd(8'h20, d); chk("R10 rx flushed read", d, 0);
    rxp(32'h99);
    wr(8'h84, 32'h1234_5678);
    settle();
    chk("R10 tx held", {31'd0, tx_valid}, 0);
    wr(8'h14, 1);
    settle();
    rd(8'h20, d); chk("R10 rx push ignored", d, 0);
    pop_expect("R10 tx queued while off", 32'h1234_5678, 3'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_sizes();
    t_tx_full();
    t_w1c();
    t_txwm();
    t_rx();
    t_irq();
    t_disable();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule